// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block adds two 16-bit unsigned operands and a carry-in and returns a 16-bit sum with a carry-out. It is purely combinational: there is no clock, no state and no handshake. A datapath drops it in wherever a wide addition must settle in a fixed, shallow number of gate levels instead of a delay that grows with every bit.

The operands are cut into 4-bit slices. Each slice forms a generate term (the AND of its two operand bits) and a propagate term (their XOR) for every bit. It then computes each internal carry as one flat sum of products over those terms and the slice carry-in. It also reports a slice-wide generate and propagate. A second look-ahead stage uses the same flat form on the four slice pairs and the external carry-in. That stage produces the carry into every slice and the final carry-out. Each sum bit is its propagate term XORed with the carry arriving at that bit. The slice width and the operand width are parameters.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin taken as unsigned numbers.
- R2: With a equal to zero and cin low, sum equals b and cout is 0. This includes the all-zero vector.
- R3: All-ones plus zero with cin high gives sum 0 and cout 1. All-ones plus all-ones with cin high gives sum all-ones and cout 1.
- R4: The carry into slice k (bits 4k and up) equals the carry out of adding the bits below 4k of both operands plus cin. So a low part of all ones with b zero and cin high gives sum = 1 << 4k.
- R5: A slice whose operand bits are pairwise complementary passes its carry-in through unchanged. 0x5555 + 0xAAAA gives 0xFFFF with cout 0 when cin is 0, and 0x0000 with cout 1 when cin is 1.
- R6: A slice whose top bit pair is 1,1 produces a carry-out of 1 whatever its carry-in is. For example 0x8888 + 0x8888 gives sum 0x1110 with cout 1.
- R7: Swapping a and b leaves sum and cout unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, unsigned |
| b | input | 16 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the addition |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach is a carry that starts at bit 0 and must cross every slice through propagate terms alone. Random operands almost never make three or four slices propagate at once. The stimulus therefore builds that case directly. It sets every slice below a chosen boundary to all ones, sets the other operand to zero and raises cin, and it repeats this for each slice boundary. Random vectors and their operand-swapped copies then cover mixed generate and propagate patterns.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Widest generate/propagate vector the look-ahead function accepts.
    localparam int unsigned LA_MAX = 16;

    // Carry into position n of a look-ahead span, written as one flat OR of
    // product terms: each generate g[k] below n ANDed with every propagate
    // between k+1 and n-1, plus c0 ANDed with all propagates below n.
    function automatic logic la_carry(
        input logic [LA_MAX-1:0] g,
        input logic [LA_MAX-1:0] p,
        input logic              c0,
        input int unsigned       n
    );
        logic acc;
        logic term;
        acc = 1'b0;
        for (int unsigned k = 0; k < LA_MAX; k++) begin
            if (k < n) begin
                term = g[k];
                for (int unsigned m = 0; m < LA_MAX; m++) begin
                    if (m > k && m < n) begin
                        term = term & p[m];
                    end
                end
                acc = acc | term;
            end
        end
        term = c0;
        for (int unsigned m = 0; m < LA_MAX; m++) begin
            if (m < n) begin
                term = term & p[m];
            end
        end
        return acc | term;
    endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg (
    input  logic op_x,
    input  logic op_y,
    output logic gen,
    output logic prop
);
    always_comb begin
        gen  = op_x & op_y;
        prop = op_x ^ op_y;
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W = 4
) (
    input  logic [GRP_W-1:0] op_x,
    input  logic [GRP_W-1:0] op_y,
    input  logic             c_in,
    output logic [GRP_W-1:0] s_out,
    output logic             grp_g,
    output logic             grp_p
);
    logic [GRP_W-1:0] g_bit;
    logic [GRP_W-1:0] p_bit;
    logic [GRP_W-1:0] c_bit;
    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;

    for (genvar i = 0; i < GRP_W; i++) begin : g_bits
        cla_bit_pg u_pg (
            .op_x (op_x[i]),
            .op_y (op_y[i]),
            .gen  (g_bit[i]),
            .prop (p_bit[i])
        );
    end

    always_comb begin
        g_ext = LA_MAX'(g_bit);
        p_ext = LA_MAX'(p_bit);
        for (int unsigned j = 0; j < GRP_W; j++) begin
            c_bit[j] = la_carry(g_ext, p_ext, c_in, j);
        end
        s_out = p_bit ^ c_bit;
        grp_p = &p_bit;
        grp_g = la_carry(g_ext, p_ext, 1'b0, GRP_W);
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int unsigned N_GRP = 4
) (
    input  logic [N_GRP-1:0] gg,
    input  logic [N_GRP-1:0] pp,
    input  logic             c_in,
    output logic [N_GRP-1:0] grp_cin,
    output logic             c_out
);
    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;

    always_comb begin
        g_ext = LA_MAX'(gg);
        p_ext = LA_MAX'(pp);
        for (int unsigned k = 0; k < N_GRP; k++) begin
            grp_cin[k] = la_carry(g_ext, p_ext, c_in, k);
        end
        c_out = la_carry(g_ext, p_ext, c_in, N_GRP);
    end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GRP_W = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned N_GRP = WIDTH / GRP_W;

    logic [N_GRP-1:0] grp_g;
    logic [N_GRP-1:0] grp_p;
    logic [N_GRP-1:0] grp_cin;

    for (genvar k = 0; k < N_GRP; k++) begin : g_slices
        cla_group #(.GRP_W(GRP_W)) u_grp (
            .op_x  (a[k*GRP_W +: GRP_W]),
            .op_y  (b[k*GRP_W +: GRP_W]),
            .c_in  (grp_cin[k]),
            .s_out (sum[k*GRP_W +: GRP_W]),
            .grp_g (grp_g[k]),
            .grp_p (grp_p[k])
        );
    end

    cla_lookahead #(.N_GRP(N_GRP)) u_la (
        .gg      (grp_g),
        .pp      (grp_p),
        .c_in    (cin),
        .grp_cin (grp_cin),
        .c_out   (cout)
    );
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GRP_W = 4
) (
    input logic [WIDTH-1:0]       a,
    input logic [WIDTH-1:0]       b,
    input logic                   cin,
    input logic [WIDTH-1:0]       sum,
    input logic                   cout,
    input logic [WIDTH/GRP_W-1:0] grp_cin,
    input logic [WIDTH/GRP_W-1:0] grp_g,
    input logic [WIDTH/GRP_W-1:0] grp_p
);
    localparam int unsigned N_GRP = WIDTH / GRP_W;

    logic [WIDTH:0] ref_total;
    logic [WIDTH:0] low_sum;
    logic [WIDTH-1:0] low_mask;

    always_comb begin
        ref_total = (WIDTH+1)'(a) + (WIDTH+1)'(b) + (WIDTH+1)'(cin);
        assert_total_R1: assert ({cout, sum} == ref_total)
            else $error("R1 total mismatch");

        if (a == '0 && !cin) begin
            assert_identity_R2: assert (sum == b && !cout)
                else $error("R2 identity mismatch");
        end

        for (int unsigned k = 0; k < N_GRP; k++) begin
            low_mask = (WIDTH'(1) << (k*GRP_W)) - WIDTH'(1);
            low_sum  = (WIDTH+1)'(a & low_mask) + (WIDTH+1)'(b & low_mask)
                     + (WIDTH+1)'(cin);
            assert_slice_cin_R4: assert (grp_cin[k] == low_sum[k*GRP_W])
                else $error("R4 slice carry mismatch");

            if (grp_p[k]) begin
                if (k + 1 < N_GRP) begin
                    assert_pass_R5: assert (grp_cin[k+1] == grp_cin[k])
                        else $error("R5 pass-through mismatch");
                end else begin
                    assert_pass_top_R5: assert (cout == grp_cin[k])
                        else $error("R5 pass-through mismatch at top");
                end
            end

            if (grp_g[k]) begin
                if (k + 1 < N_GRP) begin
                    assert_gen_R6: assert (grp_cin[k+1])
                        else $error("R6 generated carry missing");
                end else begin
                    assert_gen_top_R6: assert (cout)
                        else $error("R6 generated carry missing at top");
                end
            end
        end
    end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .GRP_W(GRP_W)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .grp_cin (grp_cin),
    .grp_g   (grp_g),
    .grp_p   (grp_p)
);

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;
    localparam int unsigned W = 16;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
        logic [W:0]   exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         c_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;

    item_t sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    cla_adder16 u_dut (
        .a    (a_i),
        .b    (b_i),
        .cin  (c_i),
        .sum  (sum_o),
        .cout (cout_o)
    );

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string req);
        item_t it;
        @(negedge clk);
        a_i = x;
        b_i = y;
        c_i = c;
        it.a   = x;
        it.b   = y;
        it.c   = c;
        it.exp = (W+1)'(x) + (W+1)'(y) + (W+1)'(c);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: inputs change at negedge, the result is read at the next posedge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if ({cout_o, sum_o} !== it.exp) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                         it.req, it.a, it.b, it.c, {cout_o, sum_o}, it.exp);
            end
        end
    end

    initial begin
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         c;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R2: all-zero vector after reset, then identity cases
        drive('0, '0, 1'b0, "R2");
        drive('0, 16'h1234, 1'b0, "R2");
        drive('0, 16'hFFFF, 1'b0, "R2");
        // R3: all-ones corners
        drive(16'hFFFF, '0, 1'b1, "R3");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R3");
        drive(16'hFFFF, 16'hFFFF, 1'b0, "R3");
        // R4: carry rippling across each slice boundary by propagation alone
        for (int k = 1; k <= 4; k++) begin
            x = W'((17'(1) << (4*k)) - 17'(1));
            drive(x, '0, 1'b1, "R4");
            drive('0, x, 1'b1, "R4");
        end
        drive(16'hFFFF, 16'h0001, 1'b0, "R4");
        // R5: complementary operand bits pass the carry-in through
        drive(16'h5555, 16'hAAAA, 1'b0, "R5");
        drive(16'h5555, 16'hAAAA, 1'b1, "R5");
        drive(16'h0F0F, 16'hF0F0, 1'b1, "R5");
        // R6: slice top bit pair 1,1 generates a carry
        drive(16'h8888, 16'h8888, 1'b0, "R6");
        drive(16'h0800, 16'h0800, 1'b1, "R6");
        drive(16'h8000, 16'h8000, 1'b0, "R6");
        // R1 and R7: random vectors, each followed by its swapped copy
        for (int i = 0; i < 400; i++) begin
            x = W'($urandom);
            y = W'($urandom);
            c = 1'($urandom);
            drive(x, y, c, "R1");
            drive(y, x, c, "R7");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule